// File: doc/BRIEF.md
# Banked GPIO Interrupt Trigger Unit

This block watches one bank of general-purpose input pins and turns activity on them into interrupt requests. Each bit has its own trigger configuration, held across three parallel type words. A bit is edge- or level-sensitive, and either polarity is available. A bit may also fire on both edges. Every clock the pins are compared with the values captured on the previous clock. Any bit whose configured condition holds while its enable is set latches a sticky status bit. The bank drives a single summary interrupt, which is the OR of all enabled status bits.

Software reaches the bank through a flat register port with a write strobe and a word address; reads are combinational on the address. The port exposes the enable word, the three type words and the status word, which is cleared by writing ones. It also exposes a read-only view of the captured input pins and a writable output-data latch that drives the output pins. The serial transport that carries the pins and any bus bridge sit outside this block and are assumed to present synchronous inputs.

Top module: `gpio_irq_bank`

## Requirements
- R1: A bit with type1=0 and type2=1 sets its status on any change of its pin between consecutive clocks (both edges).
- R2: A bit with type1=0 and type2=0 sets its status on a 0-to-1 change when type0=1 and on a 1-to-0 change when type0=0.
- R3: A bit with type1=1 is level-sensitive: it sets its status in every cycle its pin equals type0 (type0=1 active-high, type0=0 active-low), so a clear while the level is still present leaves the bit set.
- R4: A write to the status word (byte offset 0x10) clears every status bit written as 1 and leaves bits written as 0 unchanged; status bits otherwise hold their value.
- R5: A status bit is set only when its enable bit (offset 0x00) was 1 in the cycle of the event; clearing an enable bit does not clear its status bit.
- R6: irq_o is 1 exactly when some bit has both status and enable set.
- R7: The enable, type0, type1 and type2 words sit at byte offsets 0x00, 0x04, 0x08 and 0x0C, read back what was written, and reset to zero; reads of unmapped offsets return zero and writes there change nothing.
- R8: Offset 0x14 reads the pins as captured at the most recent clock edge and ignores writes; offset 0x18 is a read/write output-data latch that resets to zero and drives out_o.
- R9: After reset the previous-pin capture tracks the pins from the first clock onward, so pins held high through reset give no edge events once edges are enabled.
- R10: When a status bit is being set and cleared by a write in the same cycle, it ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pins_i | input | WIDTH | Synchronous input pin values |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Register byte offset |
| wdata_i | input | WIDTH | Register write data |
| rdata_o | output | WIDTH | Register read data for addr_i |
| out_o | output | WIDTH | Output-data latch |
| irq_o | output | 1 | Summary interrupt |

## Verification
The bench aims at a held active level being cleared, which a clear-wins design would drop to zero for a cycle. It also covers the same-cycle collision of a set and a clear, and a write of zeros to status, which a plain-write status register would wipe. It disables an enable bit after its status latched, a case a design gating status by enable would lose, and releases reset with the pins already high, where a stale previous-pin capture would invent a rising edge. A long stretch of random pin traffic and register writes then mixes all five trigger modes with enable changes, so a wrong decode of the type words shows up as a status word differing from the reference model.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned REG_AW = 5;

  localparam logic [REG_AW-1:0] OFF_EN   = 5'h00;
  localparam logic [REG_AW-1:0] OFF_T0   = 5'h04;
  localparam logic [REG_AW-1:0] OFF_T1   = 5'h08;
  localparam logic [REG_AW-1:0] OFF_T2   = 5'h0C;
  localparam logic [REG_AW-1:0] OFF_STAT = 5'h10;
  localparam logic [REG_AW-1:0] OFF_VAL  = 5'h14;
  localparam logic [REG_AW-1:0] OFF_DOUT = 5'h18;

  typedef enum logic [2:0] {
    TRIG_FALL,
    TRIG_RISE,
    TRIG_BOTH,
    TRIG_LOW,
    TRIG_HIGH
  } trig_e;

  function automatic trig_e trig_decode(logic t0, logic t1, logic t2);
    if (t1)      return t0 ? TRIG_HIGH : TRIG_LOW;
    else if (t2) return TRIG_BOTH;
    else         return t0 ? TRIG_RISE : TRIG_FALL;
  endfunction
endpackage

// File: rtl/gpio_irq_cfg.sv
module gpio_irq_cfg
  import gpio_irq_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [WIDTH-1:0]  wdata_i,
  output logic [WIDTH-1:0]  en_o,
  output logic [WIDTH-1:0]  t0_o,
  output logic [WIDTH-1:0]  t1_o,
  output logic [WIDTH-1:0]  t2_o,
  output logic [WIDTH-1:0]  dout_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o   <= '0;
      t0_o   <= '0;
      t1_o   <= '0;
      t2_o   <= '0;
      dout_o <= '0;
    end else if (wr_i) begin
      case (addr_i)
        OFF_EN:   en_o   <= wdata_i;
        OFF_T0:   t0_o   <= wdata_i;
        OFF_T1:   t1_o   <= wdata_i;
        OFF_T2:   t2_o   <= wdata_i;
        OFF_DOUT: dout_o <= wdata_i;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] pins_i,
  input  logic [WIDTH-1:0] en_i,
  input  logic [WIDTH-1:0] t0_i,
  input  logic [WIDTH-1:0] t1_i,
  input  logic [WIDTH-1:0] t2_i,
  output logic [WIDTH-1:0] prev_o,
  output logic [WIDTH-1:0] hit_o
);
  logic [WIDTH-1:0] prev_q;

  // tracks pins from the first edge out of reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= pins_i;
  end

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    trig_e mode;
    logic  evt;
    always_comb begin
      mode = trig_decode(t0_i[b], t1_i[b], t2_i[b]);
      case (mode)
        TRIG_RISE: evt = pins_i[b] & ~prev_q[b];
        TRIG_FALL: evt = ~pins_i[b] & prev_q[b];
        TRIG_BOTH: evt = pins_i[b] ^ prev_q[b];
        TRIG_HIGH: evt = pins_i[b];
        TRIG_LOW:  evt = ~pins_i[b];
        default:   evt = 1'b0;
      endcase
    end
    assign hit_o[b] = evt & en_i[b];
  end

  assign prev_o = prev_q;
endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] hit_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] status_o
);
  // set has priority over write-one-to-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_o <= '0;
    else         status_o <= (status_o & ~clr_i) | hit_i;
  end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WIDTH-1:0]  pins_i,
  input  logic              wr_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [WIDTH-1:0]  wdata_i,
  output logic [WIDTH-1:0]  rdata_o,
  output logic [WIDTH-1:0]  out_o,
  output logic              irq_o
);
  logic [WIDTH-1:0] en_q, t0_q, t1_q, t2_q, dout_q;
  logic [WIDTH-1:0] prev_q, hit, clr, status_q;

  gpio_irq_cfg #(.WIDTH(WIDTH)) cfg_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .en_o   (en_q),
    .t0_o   (t0_q),
    .t1_o   (t1_q),
    .t2_o   (t2_q),
    .dout_o (dout_q)
  );

  gpio_irq_detect #(.WIDTH(WIDTH)) det_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pins_i(pins_i),
    .en_i  (en_q),
    .t0_i  (t0_q),
    .t1_i  (t1_q),
    .t2_i  (t2_q),
    .prev_o(prev_q),
    .hit_o (hit)
  );

  assign clr = (wr_i && addr_i == OFF_STAT) ? wdata_i : '0;

  gpio_irq_status #(.WIDTH(WIDTH)) st_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hit_i   (hit),
    .clr_i   (clr),
    .status_o(status_q)
  );

  always_comb begin
    case (addr_i)
      OFF_EN:   rdata_o = en_q;
      OFF_T0:   rdata_o = t0_q;
      OFF_T1:   rdata_o = t1_q;
      OFF_T2:   rdata_o = t2_q;
      OFF_STAT: rdata_o = status_q;
      OFF_VAL:  rdata_o = prev_q;
      OFF_DOUT: rdata_o = dout_q;
      default:  rdata_o = '0;
    endcase
  end

  assign out_o = dout_q;
  assign irq_o = |(status_q & en_q);
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk
  import gpio_irq_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_i,
  input logic [REG_AW-1:0] addr_i,
  input logic [WIDTH-1:0]  wdata_i,
  input logic [WIDTH-1:0]  en_i,
  input logic [WIDTH-1:0]  status_i,
  input logic [WIDTH-1:0]  hit_i,
  input logic              irq_i
);
  logic [WIDTH-1:0] clr_req;
  always_comb clr_req = (wr_i && addr_i == OFF_STAT) ? wdata_i : '0;

  // R5: new status bits only where enable was set
  p_set_gated_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_i & ~$past(status_i) & ~$past(en_i)) == '0));

  // R4: a status bit drops only under a written one
  p_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(status_i) & ~status_i & ~$past(clr_req)) == '0));

  // R10: a detected event always lands in status
  p_set_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(hit_i) & ~status_i) == '0));

  // R6: summary needs an enabled pending bit
  p_irq_src_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> ((status_i & en_i) != '0));
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.WIDTH(WIDTH)) chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_i    (wr_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .en_i    (en_q),
  .status_i(status_q),
  .hit_i   (hit),
  .irq_i   (irq_o)
);

// File: tb/gpio_irq_bank_tb_top.sv
`timescale 1ns/1ps
module gpio_irq_bank_tb_top;
  localparam int W = 32;
  localparam logic [4:0] A_EN = 5'h00, A_T0 = 5'h04, A_T1 = 5'h08, A_T2 = 5'h0C,
                         A_ST = 5'h10, A_VAL = 5'h14, A_DOUT = 5'h18, A_NONE = 5'h1C;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] pins = '0;
  logic         wr = 1'b0;
  logic [4:0]   addr = A_ST;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata, dout;
  logic         irq;

  int    checks = 0;
  int    bad = 0;
  bit    done = 0;
  string cur_req = "R7";

  always #2.5 clk = ~clk;

  gpio_irq_bank #(.WIDTH(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pins_i(pins), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .out_o(dout), .irq_o(irq)
  );

  // reference model
  bit [W-1:0] m_en, m_t0, m_t1, m_t2, m_st, m_out, m_prev;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = '0; m_t0 = '0; m_t1 = '0; m_t2 = '0; m_st = '0; m_out = '0; m_prev = '0;
    end else begin
      bit [W-1:0] hits, clr;
      hits = '0;
      for (int i = 0; i < W; i++) begin
        bit p, q, e;
        p = pins[i]; q = m_prev[i];
        if (m_t1[i])      e = m_t0[i] ? p : !p;
        else if (m_t2[i]) e = (p != q);
        else if (m_t0[i]) e = p && !q;
        else              e = !p && q;
        hits[i] = e && m_en[i];
      end
      clr = (wr && addr == A_ST) ? wdata : '0;
      m_st = (m_st & ~clr) | hits;
      if (wr) begin
        if (addr == A_EN)   m_en  = wdata;
        if (addr == A_T0)   m_t0  = wdata;
        if (addr == A_T1)   m_t1  = wdata;
        if (addr == A_T2)   m_t2  = wdata;
        if (addr == A_DOUT) m_out = wdata;
      end
      m_prev = pins;
    end
  end

  function automatic logic [W-1:0] exp_rd(logic [4:0] a);
    case (a)
      A_EN:   return m_en;
      A_T0:   return m_t0;
      A_T1:   return m_t1;
      A_T2:   return m_t2;
      A_ST:   return m_st;
      A_VAL:  return m_prev;
      A_DOUT: return m_out;
      default: return '0;
    endcase
  endfunction

  task automatic compare();
    logic [W-1:0] er;
    logic ei;
    er = exp_rd(addr);
    ei = |(m_st & m_en);
    checks++;
    if (rdata !== er) begin
      bad++;
      $display("FAIL %s rdata addr=%h act=%h exp=%h", cur_req, addr, rdata, er);
    end
    checks++;
    if (irq !== ei) begin
      bad++;
      $display("FAIL R6 irq act=%b exp=%b", irq, ei);
    end
    checks++;
    if (dout !== m_out) begin
      bad++;
      $display("FAIL R8 out act=%h exp=%h", dout, m_out);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    compare();
  endtask

  task automatic wreg(logic [4:0] a, logic [W-1:0] d);
    tick();
    wr = 1'b1; addr = a; wdata = d;
    tick();
    wr = 1'b0; addr = A_ST;
  endtask

  task automatic rreg(logic [4:0] a);
    tick();
    addr = a;
    tick();
    addr = A_ST;
  endtask

  task automatic drive(logic [W-1:0] p);
    tick();
    pins = p;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    bad++;
    checks++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    // R7: reset values
    cur_req = "R7";
    rreg(A_EN); rreg(A_T0); rreg(A_T1); rreg(A_T2); rreg(A_DOUT); rreg(A_VAL);
    tick();
    rst_n = 1'b1;
    // R7: readback and unmapped offsets
    wreg(A_EN, 32'hA5A5_0001); rreg(A_EN);
    wreg(A_T0, 32'h1234_5678); rreg(A_T0);
    wreg(A_T1, 32'h0F0F_0F0F); rreg(A_T1);
    wreg(A_T2, 32'hFFFF_0000); rreg(A_T2);
    wreg(A_NONE, 32'hFFFF_FFFF); rreg(A_NONE); rreg(A_EN);
    // bit0 both, bit1 rise, bit2 fall, bit3 high, bit4 low
    wreg(A_EN, 32'h0);
    wreg(A_T0, 32'h0000_000A);
    wreg(A_T1, 32'h0000_0018);
    wreg(A_T2, 32'h0000_0001);
    drive(32'h0000_0010);
    wreg(A_ST, 32'hFFFF_FFFF);
    wreg(A_EN, 32'h0000_001F);
    // R1 / R2: edges
    cur_req = "R1";
    drive(32'h0000_0011); drive(32'h0000_0011);
    wreg(A_ST, 32'h1);
    drive(32'h0000_0010);
    cur_req = "R2";
    drive(32'h0000_0016); drive(32'h0000_0016);
    wreg(A_ST, 32'hFFFF_FFFF);
    drive(32'h0000_0010); drive(32'h0000_0010);
    // R3 / R10: held levels survive a clear
    cur_req = "R3";
    drive(32'h0000_0008);
    wreg(A_ST, 32'hFFFF_FFFF);
    tick();
    cur_req = "R10";
    wreg(A_ST, 32'h0000_0008);
    drive(32'h0000_0010);
    cur_req = "R3";
    wreg(A_ST, 32'hFFFF_FFFF);
    tick();
    // R4: zeros do not clear
    cur_req = "R4";
    drive(32'h0000_0013); drive(32'h0000_0010);
    wreg(A_ST, 32'h0);
    wreg(A_ST, 32'h0000_0001);
    // R5: disabled bit keeps status, no new sets
    cur_req = "R5";
    wreg(A_EN, 32'h0000_001E);
    drive(32'h0000_0011); drive(32'h0000_0010);
    rreg(A_ST);
    wreg(A_EN, 32'h0000_001F);
    // R8: value and output latch
    cur_req = "R8";
    drive(32'hDEAD_BEEF);
    rreg(A_VAL);
    wreg(A_VAL, 32'h0); rreg(A_VAL);
    wreg(A_DOUT, 32'hCAFE_F00D); rreg(A_DOUT);
    // R9: pins high through reset
    cur_req = "R9";
    tick();
    pins = '1; rst_n = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
    wreg(A_T2, 32'hFFFF_FFFF);
    wreg(A_EN, 32'hFFFF_FFFF);
    tick(); tick(); rreg(A_ST);
    // random mix
    cur_req = "R1";
    for (int n = 0; n < 4000; n++) begin
      tick();
      pins = (($urandom % 4) == 0) ? $urandom : pins ^ (W'(1) << ($urandom % W));
      wr = (($urandom % 5) == 0);
      case ($urandom % 8)
        0: addr = A_EN;   1: addr = A_T0;   2: addr = A_T1; 3: addr = A_T2;
        4: addr = A_ST;   5: addr = A_VAL;  6: addr = A_DOUT; default: addr = A_NONE;
      endcase
      wdata = $urandom;
    end
    tick();
    wr = 1'b0;
    tick();
    finish_run();
  end
endmodule